// File: doc/BRIEF.md
# Bus Master START Sequencer with Collision Abort

This block produces the opening START condition of a two-wire serial bus transaction for a controller that may share the bus with other masters. On a start request it first checks that both lines are released. It then holds SDA released for a timed interval, pulls SDA low, waits a second timed interval and pulls SCL low. Both intervals come from a down-counter that loads a 7-bit reload value, so each interval lasts reload+1 clock cycles.

The pins are driven open-drain. The block only outputs drive-low enables, and it reads the wired bus levels back through a two-flop synchronizer. The block stops the sequence and raises a sticky collision flag in two cases: a line is already low when the request is taken, or SCL drops while SDA is still high during the first interval. SDA falling early in the first interval means another master started first. That is not a fault: the block pulls SDA at once and goes on with the second interval. During the second interval SCL activity is ignored.

After completion both lines stay pulled low for the transfer that follows. The next start request only releases them.

Top module: `i2c_start_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, sda_drive_low, scl_drive_low, done, collision and busy are all 0.
- R2: sda_in and scl_in reach the control logic through a two-flop synchronizer. A line change made between clock edges k and k+1 first affects the outputs at edge k+3.
- R3: A request taken in idle while either synchronized line reads 0 sets collision on that same edge. busy stays 0 and neither drive-low enable asserts.
- R4: A request taken in idle with both lines high sets busy on the acceptance edge A. With SDA and SCL left high, sda_drive_low asserts at edge A+reload+1.
- R5: scl_drive_low asserts reload+1 edges after sda_drive_low. done is 1 for exactly that one cycle, busy falls on the same edge, and sda_drive_low stays 1.
- R6: In the first interval, a synchronized SCL of 0 with synchronized SDA of 1 sets collision. busy drops and no drive-low enable asserts.
- R7: In the first interval, a synchronized SDA of 0 is not a collision. sda_drive_low asserts on that edge and the second interval of reload+1 edges starts from there.
- R8: During the second interval, a low SCL neither sets collision nor changes when done occurs.
- R9: busy is 1 from the acceptance edge until the done edge or the abort edge. Requests while busy are ignored and do not shift the timing.
- R10: collision stays 1 until clr_flag is sampled 1, and then clears on that edge. When a set and a clear occur on the same edge, the set wins.
- R11: After done, both drive-low enables stay 1. The next start request releases both and returns to idle without beginning a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| start_req | input | 1 | Request a START (or release the held lines after one) |
| sda_in | input | 1 | Wired SDA level read back from the pin |
| scl_in | input | 1 | Wired SCL level read back from the pin |
| reload | input | 7 | Interval reload value; each interval lasts reload+1 cycles |
| clr_flag | input | 1 | Clears the collision flag |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| done | output | 1 | One-cycle pulse when SCL is first pulled low |
| collision | output | 1 | Sticky bus collision flag |
| busy | output | 1 | START sequence in progress |

## Verification
The hardest cases are the ones that depend on exactly where in the first interval another master moves a line. The early SDA fall and the SCL collision must both land after acceptance but before the first count expires, and the synchronizer adds two edges of lag on top. The bench models the wired-AND bus with a second open-drain source. It pulls that source low on a chosen negative edge, a fixed number of cycles after acceptance, with a long reload value so the event is seen mid-interval. The scoreboard then expects the SDA drive or the collision exactly three edges later. A second pull on SCL inside the second interval shows that it is ignored.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // lines released, waiting for a request
    ST_PH1  = 2'd1,  // SDA released, first interval
    ST_PH2  = 2'd2,  // SDA pulled low, second interval
    ST_HOLD = 2'd3   // START complete, both lines held low
  } start_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // Idle bus level is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_brg.sv
module i2c_brg #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                       cnt_d = load_val;
    else if (dec_en && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic sda_s,
  input  logic scl_s,
  input  logic clr_flag,
  input  logic brg_zero,
  output logic brg_load,
  output logic brg_dec,
  output logic sda_low,
  output logic scl_low,
  output logic done,
  output logic coll,
  output logic busy
);
  start_state_t st_q, st_d;
  logic sda_q, sda_d, scl_q, scl_d, done_q, done_d, coll_q, coll_d;
  logic set_coll;

  always_comb begin
    st_d     = st_q;
    sda_d    = sda_q;
    scl_d    = scl_q;
    done_d   = 1'b0;
    set_coll = 1'b0;
    brg_load = 1'b0;
    brg_dec  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          if (!sda_s || !scl_s) begin
            set_coll = 1'b1;            // line already low
          end else begin
            st_d     = ST_PH1;
            brg_load = 1'b1;
          end
        end
      end
      ST_PH1: begin
        if (sda_s && !scl_s) begin
          set_coll = 1'b1;              // another master drives SCL
          st_d     = ST_IDLE;
        end else if (!sda_s || brg_zero) begin
          sda_d    = 1'b1;              // early or on-time SDA fall
          brg_load = 1'b1;
          st_d     = ST_PH2;
        end else begin
          brg_dec = 1'b1;
        end
      end
      ST_PH2: begin
        if (brg_zero) begin
          scl_d  = 1'b1;
          done_d = 1'b1;
          st_d   = ST_HOLD;
        end else begin
          brg_dec = 1'b1;
        end
      end
      ST_HOLD: begin
        if (start_req) begin
          sda_d = 1'b0;
          scl_d = 1'b0;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    coll_d = coll_q;
    if (set_coll)      coll_d = 1'b1;
    else if (clr_flag) coll_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sda_q  <= 1'b0;
      scl_q  <= 1'b0;
      done_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sda_q  <= sda_d;
      scl_q  <= scl_d;
      done_q <= done_d;
      coll_q <= coll_d;
    end
  end

  assign sda_low = sda_q;
  assign scl_low = scl_q;
  assign done    = done_q;
  assign coll    = coll_q;
  assign busy    = (st_q == ST_PH1) || (st_q == ST_PH2);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                sda_in,
  input  logic                scl_in,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                clr_flag,
  output logic                sda_drive_low,
  output logic                scl_drive_low,
  output logic                done,
  output logic                collision,
  output logic                busy
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  logic brg_load, brg_dec, brg_zero;

  i2c_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );

  i2c_brg #(.CNT_W(RELOAD_W)) brg_i (
    .clk(clk), .rst_n(rst_n), .load(brg_load), .dec_en(brg_dec),
    .load_val(reload), .at_zero(brg_zero)
  );

  i2c_start_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .sda_s(lines_s[0]), .scl_s(lines_s[1]), .clr_flag(clr_flag),
    .brg_zero(brg_zero), .brg_load(brg_load), .brg_dec(brg_dec),
    .sda_low(sda_drive_low), .scl_low(scl_drive_low), .done(done),
    .coll(collision), .busy(busy)
  );
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_flag,
  input logic sda_drive_low,
  input logic scl_drive_low,
  input logic done,
  input logic collision,
  input logic busy
);
  // R5: done lasts a single cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: at done both lines are pulled low
  assert_done_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_drive_low && sda_drive_low && !busy));
  // R5: SCL is only pulled while SDA is already pulled
  assert_scl_after_sda_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> $past(sda_drive_low));
  // R6: an abort leaves both lines released and the block idle
  assert_abort_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(collision) |-> (!sda_drive_low && !scl_drive_low && !busy));
  // R10: the flag holds without a clear
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && !clr_flag) |=> collision);
  // R9: SCL is never pulled during the sequence itself
  assert_busy_no_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !scl_drive_low);
endmodule

bind i2c_start_gen i2c_start_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clr_flag(clr_flag),
  .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
  .done(done), .collision(collision), .busy(busy)
);

// File: tb/i2c_start_gen_tb_top.sv
module i2c_start_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic clr_flag = 1'b0;
  logic [6:0] reload = '0;
  logic ext_sda_low = 1'b0;
  logic ext_scl_low = 1'b0;
  logic sda_drive_low, scl_drive_low, done, collision, busy;
  logic sda_in, scl_in;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct { bit coll; int sda_c; int end_c; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // wired-AND bus with a second open-drain master
  assign sda_in = ~sda_drive_low & ~ext_sda_low;
  assign scl_in = ~scl_drive_low & ~ext_scl_low;

  i2c_start_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .sda_in(sda_in),
    .scl_in(scl_in), .reload(reload), .clr_flag(clr_flag),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .done(done), .collision(collision), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: issues a request and pushes the expected outcome
  task automatic issue(input logic [6:0] n, input bit coll,
                       input int sda_off, input int end_off, output int a);
    exp_t e;
    @(negedge clk);
    reload = n;
    start_req = 1'b1;
    a = cyc + 1;
    e.coll  = coll;
    e.sda_c = (sda_off < 0) ? -1 : a + sda_off;
    e.end_c = a + end_off;
    exp_q.push_back(e);
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic release_hold(input string tag);
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(!sda_drive_low && !scl_drive_low && !busy, tag, "release drives+busy",
        {sda_drive_low, scl_drive_low, busy}, 0);
    repeat (4) @(negedge clk);
    chk(!sda_drive_low && !busy, tag, "no new start after release",
        {sda_drive_low, busy}, 0);
  endtask

  // monitor: compares observed outcomes against the queue
  int sda_seen = -1;
  logic prev_sda = 1'b0, prev_coll = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      if (sda_drive_low && !prev_sda) sda_seen = cyc;
      if (done || (collision && !prev_coll)) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected outcome at cycle", cyc, -1);
        end else begin
          e = exp_q.pop_front();
          chk(e.coll == (collision && !prev_coll && !done), "R3/R6/R7",
              "outcome kind collision", int'(collision), int'(e.coll));
          chk(cyc == e.end_c, "R5/R6", "outcome cycle", cyc, e.end_c);
          chk(sda_seen == e.sda_c, "R4/R7", "SDA pull cycle", sda_seen, e.sda_c);
        end
        sda_seen = -1;
      end
      prev_sda  = sda_drive_low;
      prev_coll = collision;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int a;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({sda_drive_low, scl_drive_low, done, collision, busy} == 5'b0,
        "R1", "outputs in reset", {sda_drive_low, scl_drive_low, done, collision, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sda_drive_low, scl_drive_low, done, collision, busy} == 5'b0,
        "R1", "outputs after reset", {sda_drive_low, scl_drive_low, done, collision, busy}, 0);
    repeat (3) @(negedge clk);

    // R4 R5: plain START, reload 10
    issue(7'd10, 0, 11, 22, a);
    chk(busy == 1'b1, "R9", "busy after acceptance", busy, 1);
    repeat (23) @(negedge clk);
    chk(sda_drive_low && scl_drive_low && !busy, "R11", "held after done",
        {sda_drive_low, scl_drive_low, busy}, 3'b110);
    release_hold("R11");

    // R4 R5: reload 0, shortest intervals
    issue(7'd0, 0, 1, 2, a);
    repeat (3) @(negedge clk);
    release_hold("R11");

    // R9: a request while busy is ignored
    issue(7'd3, 0, 4, 8, a);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(busy == 1'b1, "R9", "busy during sequence", busy, 1);
    repeat (8) @(negedge clk);
    release_hold("R9");

    // R7 R2: other master pulls SDA early; R8: SCL low in second interval
    issue(7'd10, 0, 5, 16, a);
    repeat (2) @(negedge clk);
    ext_sda_low = 1'b1;
    repeat (4) @(negedge clk);
    ext_scl_low = 1'b1;
    repeat (3) @(negedge clk);
    ext_scl_low = 1'b0;
    ext_sda_low = 1'b0;
    repeat (8) @(negedge clk);
    chk(collision == 1'b0, "R8", "no collision from SCL in interval two", collision, 0);
    release_hold("R11");

    // R6: SCL pulled low while SDA high in first interval
    issue(7'd10, 1, -1, 5, a);
    repeat (2) @(negedge clk);
    ext_scl_low = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !sda_drive_low && !scl_drive_low, "R6", "idle after abort",
        {busy, sda_drive_low, scl_drive_low}, 0);
    ext_scl_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(collision == 1'b1, "R10", "flag sticky", collision, 1);
    clr_flag = 1'b1;
    @(negedge clk);
    clr_flag = 1'b0;
    chk(collision == 1'b0, "R10", "flag cleared", collision, 0);
    repeat (12) @(negedge clk);
    chk(!sda_drive_low && !busy, "R6", "no late SDA pull after abort",
        {sda_drive_low, busy}, 0);

    // R3: SDA already low at request
    ext_sda_low = 1'b1;
    repeat (4) @(negedge clk);
    issue(7'd5, 1, -1, 0, a);
    chk(!busy && !sda_drive_low, "R3", "no start on low SDA",
        {busy, sda_drive_low}, 0);
    ext_sda_low = 1'b0;
    clr_flag = 1'b1;
    @(negedge clk);
    clr_flag = 1'b0;
    repeat (4) @(negedge clk);

    // R3 R10: SCL already low, clear held on the same edge: set wins
    ext_scl_low = 1'b1;
    repeat (4) @(negedge clk);
    clr_flag = 1'b1;
    issue(7'd5, 1, -1, 0, a);
    clr_flag = 1'b0;
    chk(collision == 1'b1, "R10", "set wins over clear", collision, 1);
    ext_scl_low = 1'b0;
    repeat (2) @(negedge clk);
    chk(collision == 1'b1 && !busy, "R3", "flag kept, idle", {collision, busy}, 2'b10);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all expected outcomes seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule